// File: doc/BRIEF.md
# Sequential Radix-2 Unsigned Divider

This block divides one unsigned W-bit operand by another over several clock cycles and returns a W-bit quotient and a W-bit remainder. It settles one quotient bit per clock. A single working register keeps the partial remainder in its upper part and collects quotient bits at the bottom of its lower part. After the working register is loaded, it is shifted left once. Each step then applies the divisor to the upper part and shifts in one quotient bit. After the last step, the upper part shifted right by one gives the remainder.

A mode input, sampled when an operation is accepted, selects how negative partial remainders are handled. In restoring mode, a failed trial subtraction is undone before the shift. In non-restoring mode, a negative partial remainder is kept and the divisor is added, rather than subtracted, on the following step. A final correction adds the divisor back if the last partial remainder is negative. Both modes return the same results. A zero divisor is reported at once rather than iterated.

Top module: `seq_divider`

## Requirements
- R1: After reset, busy, done, div_zero, quotient and remainder are all zero.
- R2: A start pulse seen while busy is low, with a non-zero divisor, makes busy high and done and div_zero low from the next cycle. busy and done are never high together.
- R3: busy stays high for exactly W cycles. done rises in the cycle after busy falls.
- R4: With nonrestore = 0 at start, the results are quotient = dividend / divisor and remainder = dividend % divisor, taken as unsigned integers.
- R5: With nonrestore = 1 at start, the results are the same integer quotient and remainder as in R4.
- R6: While done is high and no start pulse arrives, done, quotient and remainder hold their values, whatever the operand inputs do.
- R7: A start pulse while busy is high is ignored: the running operation keeps its operands and its timing.
- R8: A start pulse with divisor = 0 sets done = 1 and div_zero = 1 in the next cycle, with busy kept low. In that case quotient is all ones and remainder equals the dividend.
- R9: div_zero falls when the next operation with a non-zero divisor is accepted.
- R10: Changes on nonrestore or on the operand inputs after an operation is accepted do not change its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin a division |
| nonrestore | input | 1 | 0 selects restoring steps, 1 selects non-restoring steps; sampled with start |
| dividend | input | W | Unsigned dividend, sampled with start |
| divisor | input | W | Unsigned divisor, sampled with start |
| busy | output | 1 | An operation is iterating |
| done | output | 1 | Results are valid; held until the next accepted start |
| div_zero | output | 1 | The last accepted operation had a zero divisor |
| quotient | output | W | Unsigned quotient |
| remainder | output | W | Unsigned remainder |

## Verification
Every operand pair is run in both modes and checked against the integer division and modulo operators. Random pairs with divisors scaled down by random shifts make the partial remainder change sign many times, which exercises the add/subtract alternation and the final correction in non-restoring mode. Corner pairs separate the edge cases of the shift structure: zero and all-ones dividends, a divisor of one, equal operands, a divisor larger than the dividend, and a dividend with only its top bit set. Directed sequences send pulses during an operation, flip the mode partway through, idle after completion, and chain a zero-divisor request with a normal one. These sequences separate ignored requests from accepted ones.

// File: rtl/seq_divider.sv
module seq_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         nonrestore,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic         div_zero,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder
);
  localparam int HW = W + 2;
  localparam int CW = $clog2(W) + 1;

  logic signed [HW-1:0] hi;
  logic [W-1:0]         lo;
  logic [W-1:0]         dsr;
  logic                 mode;
  logic                 neg;
  logic [CW-1:0]        cnt;

  wire signed [HW-1:0] dx    = signed'({2'b00, dsr});
  wire signed [HW-1:0] trial = (mode && neg) ? hi + dx : hi - dx;
  wire                 tneg  = trial[HW-1];
  wire signed [HW-1:0] kept  = (!mode && tneg) ? hi : trial;
  wire signed [HW-1:0] hi_sh = {kept[HW-2:0], lo[W-1]};
  wire [W-1:0]         lo_sh = {lo[W-2:0], ~tneg};
  wire signed [HW-1:0] half  = hi_sh >>> 1;
  wire signed [HW-1:0] fixed = half[HW-1] ? half + dx : half;
  wire                 last  = (cnt == CW'(W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi        <= '0;
      lo        <= '0;
      dsr       <= '0;
      mode      <= 1'b0;
      neg       <= 1'b0;
      cnt       <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      div_zero  <= 1'b0;
      quotient  <= '0;
      remainder <= '0;
    end else if (busy) begin
      hi  <= hi_sh;
      lo  <= lo_sh;
      neg <= tneg;
      cnt <= cnt + 1'b1;
      if (last) begin
        busy      <= 1'b0;
        done      <= 1'b1;
        quotient  <= lo_sh;
        remainder <= fixed[W-1:0];
      end
    end else if (start) begin
      if (divisor == '0) begin
        done      <= 1'b1;
        div_zero  <= 1'b1;
        quotient  <= '1;
        remainder <= dividend;
      end else begin
        busy     <= 1'b1;
        done     <= 1'b0;
        div_zero <= 1'b0;
        hi       <= {{(HW-1){1'b0}}, dividend[W-1]};
        lo       <= {dividend[W-2:0], 1'b0};
        dsr      <= divisor;
        mode     <= nonrestore;
        neg      <= 1'b0;
        cnt      <= '0;
      end
    end
  end
endmodule

// File: rtl/seq_divider_checks.sv
module seq_divider_checks #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [W-1:0] divisor,
  input logic         busy,
  input logic         done,
  input logic         div_zero,
  input logic [W-1:0] quotient,
  input logic [W-1:0] remainder
);
  localparam int CW = $clog2(W + 1) + 1;
  logic [CW-1:0] span;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    span <= '0;
    else if (busy) span <= span + 1'b1;
    else           span <= '0;
  end

  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done)); // R2
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && divisor != '0) |=> (busy && !done && !div_zero)); // R2
  AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (span < CW'(W))); // R3
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done && span == CW'(W))); // R3
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(quotient) && $stable(remainder))); // R6
  AST_ZERO_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && divisor == '0) |=> (done && div_zero && !busy && quotient == '1)); // R8
endmodule

bind seq_divider seq_divider_checks #(.W(W)) i_checks (
  .clk(clk), .rst_n(rst_n), .start(start), .divisor(divisor),
  .busy(busy), .done(done), .div_zero(div_zero),
  .quotient(quotient), .remainder(remainder)
);

// File: tb/test_seq_divider.sv
module test_seq_divider;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         nonrestore = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic         busy, done, div_zero;
  logic [W-1:0] quotient, remainder;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit finished = 0;

  seq_divider #(.W(W)) i_seq_divider (
    .clk(clk), .rst_n(rst_n), .start(start), .nonrestore(nonrestore),
    .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
    .div_zero(div_zero), .quotient(quotient), .remainder(remainder)
  );

  always #5 clk = ~clk;

  // behavioural reference, updated on every rising edge
  logic         m_busy = 0, m_done = 0, m_dz = 0, m_mode = 0;
  logic [W-1:0] m_q = '0, m_r = '0, m_a = '0, m_b = '0;
  int           m_cnt = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_dz = 0; m_q = '0; m_r = '0; m_cnt = 0;
    end else if (m_busy) begin
      m_cnt++;
      if (m_cnt == W) begin
        m_busy = 0; m_done = 1; m_q = m_a / m_b; m_r = m_a % m_b;
      end
    end else if (start) begin
      if (divisor == '0) begin
        m_done = 1; m_dz = 1; m_q = '1; m_r = dividend;
      end else begin
        m_busy = 1; m_done = 0; m_dz = 0; m_cnt = 0;
        m_a = dividend; m_b = divisor; m_mode = nonrestore;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(busy == m_busy, "R3 busy", 64'(busy), 64'(m_busy));
      check(done == m_done, "R3 done", 64'(done), 64'(m_done));
      check(div_zero == m_dz, "R8 div_zero", 64'(div_zero), 64'(m_dz));
      if (m_done) begin
        check(quotient == m_q, m_dz ? "R8 quotient" : (m_mode ? "R5 quotient" : "R4 quotient"),
              64'(quotient), 64'(m_q));
        check(remainder == m_r, m_dz ? "R8 remainder" : (m_mode ? "R5 remainder" : "R4 remainder"),
              64'(remainder), 64'(m_r));
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected<150000 cycles", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic issue(input logic [W-1:0] a, input logic [W-1:0] b, input logic m);
    @(negedge clk);
    start = 1; dividend = a; divisor = b; nonrestore = m;
    @(negedge clk);
    start = 0;
  endtask

  task automatic finish_op();
    while (!done) @(negedge clk);
  endtask

  task automatic run_both(input logic [W-1:0] a, input logic [W-1:0] b);
    for (int m = 0; m < 2; m++) begin
      issue(a, b, m[0]);
      finish_op();
      if (b != 0) begin
        check(quotient == a / b, m ? "R5 q direct" : "R4 q direct", 64'(quotient), 64'(a / b));
        check(remainder == a % b, m ? "R5 r direct" : "R4 r direct", 64'(remainder), 64'(a % b));
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !div_zero, "R1 flags", 64'({busy, done, div_zero}), 64'(0));
    check(quotient == 0 && remainder == 0, "R1 results", 64'(quotient) ^ 64'(remainder), 64'(0));
    rst_n = 1;
    @(negedge clk);

    // R4 R5 corner operands
    run_both(32'd7, 32'd2);
    run_both(32'd0, 32'd5);
    run_both('1, 32'd1);
    run_both('1, '1);
    run_both(32'd5, 32'd9);
    run_both(32'h8000_0000, 32'd3);
    run_both(32'h8000_0000, 32'h8000_0001);
    run_both('1, 32'h7FFF_FFFF);
    run_both(32'd1000, 32'd1000);

    // R8 then R9
    issue(32'd1234, 32'd0, 1'b1);
    check(done && div_zero && !busy, "R8 immediate", 64'({busy, done, div_zero}), 64'(3));
    check(remainder == 32'd1234, "R8 remainder", 64'(remainder), 64'd1234);
    issue(32'd50, 32'd7, 1'b0);
    check(!div_zero, "R9 cleared", 64'(div_zero), 64'd0);
    finish_op();

    // R7 and R10: pulses and mode flips mid-operation
    issue(32'd1_000_003, 32'd17, 1'b1);
    repeat (4) @(negedge clk);
    start = 1; dividend = 32'd99; divisor = 32'd0; nonrestore = 0;
    @(negedge clk);
    start = 0; nonrestore = 1; dividend = '1; divisor = 32'd3;
    finish_op();
    check(quotient == 32'd1_000_003 / 17, "R7 quotient", 64'(quotient), 64'(32'd1_000_003 / 17));
    check(remainder == 32'd1_000_003 % 17 && !div_zero, "R10 remainder", 64'(remainder),
          64'(32'd1_000_003 % 17));

    // R6 hold while inputs wander
    for (int k = 0; k < 6; k++) begin
      dividend = $urandom; divisor = $urandom; nonrestore = k[0];
      @(negedge clk);
      check(done && quotient == 32'd1_000_003 / 17, "R6 hold", 64'(quotient),
            64'(32'd1_000_003 / 17));
    end

    // R4 R5 random, divisors scaled to many magnitudes
    for (int k = 0; k < 150; k++) begin
      logic [W-1:0] a, b;
      a = $urandom >> ($urandom % 8);
      b = $urandom >> ($urandom % 32);
      if (b == 0) b = 32'd1;
      run_both(a, b);
    end

    repeat (3) @(negedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule